// File: doc/BRIEF.md
# DMA Completion Interrupt Control Register

This block is the interrupt control and status register for a DMA engine. Software programs it with a 3-bit interrupt level and an enable bit. The block watches the engine's done indication. When the condition "enable AND done" goes from low to high, the block sets a pending flag. While the flag is set and the level is nonzero, the interrupt request output carries that level code. When the flag is clear, or the level is zero, the output carries level 0, which means no request.

Software clears the flag in one of two ways. It can write a 1 to the flag's bit, or it can write the enable bit low. Because the flag responds to an edge, clearing it while enable and done both stay high does not bring it back. Only a new low-to-high transition of the combined condition sets it again.

Each register write loads the level and enable fields. A read returns the flag together with the two fields.

Top module: `dma_irq_ctl`

## Requirements
- R1: During and after reset, the level, enable and pending fields read 0, and `irq_level` is 0.
- R2: A write (`wr_en` high at a clock edge) loads `wr_data[2:0]` as the level and `wr_data[3]` as the enable. The fields appear on `rd_data` in the cycle after that edge. `rd_data` is laid out as {pending at bit 7, zeros at bits 6..4, enable at bit 3, level at bits 2..0}.
- R3: Pending reads 1 in the cycle after the first cycle in which the stored enable is 1 and `dma_done` is 1. While enable is 0, `dma_done` has no effect on pending.
- R4: Once cleared, pending stays 0 while stored enable and `dma_done` both remain 1. It sets again only after their conjunction has gone low and then high again.
- R5: A write with `wr_data[7]`=1 clears pending at that edge. A write with `wr_data[7]`=0 leaves pending unchanged.
- R6: A write with `wr_data[3]`=0 clears pending at that edge, even while `dma_done` is high.
- R7: `irq_level` equals the stored level while pending is 1 and the level is nonzero. Otherwise `irq_level` is 0, so level 0 never requests an interrupt.
- R8: When a write with `wr_data[7]`=1 lands in the same cycle as a rising edge of enable AND done, pending ends up set.
- R9: A write that sets enable while `dma_done` is already 1 counts as a rising edge. Pending reads 1 one cycle after the enable becomes visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: level [2:0], enable [3], clear-pending [7] |
| rd_data | output | 8 | Register contents: pending, enable, level |
| dma_done | input | 1 | Done indication from the DMA control/status logic |
| irq_level | output | 3 | Interrupt request level; 0 means no request |

## Verification
A wrong edge-detector state shows up at the ports in one of two ways. A stale previous value either sets pending a second time while enable and done stay high, or it misses the edge produced by an enabling write. Both are visible on `rd_data[7]` and `irq_level` one cycle after the stimulus. A lost or wrongly kept pending flag shows up in the very next read, at the same time as the request level. The sequences that matter most are the ones that hold done high across clears, disables, re-enables and a clear that coincides with an edge.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned LVL_W    = 3;
    localparam int unsigned EN_POS   = 3;
    localparam int unsigned PEND_POS = 7;
endpackage

// File: rtl/dirq_cfg.sv
module dirq_cfg #(
    parameter int unsigned LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_lvl,
    input  logic             wr_enable,
    output logic [LVL_W-1:0] lvl_q,
    output logic             en_q,
    output logic             dis_wr
);
    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic             en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.lvl = wr_lvl;
            cfg_d.en  = wr_enable;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign lvl_q  = cfg_q.lvl;
    assign en_q   = cfg_q.en;
    assign dis_wr = wr_en & ~wr_enable;
endmodule

// File: rtl/dirq_rise.sv
module dirq_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } rise_t;

    rise_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cond;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = cond & ~st_q.prev;
endmodule

// File: rtl/dirq_pend.sv
module dirq_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic clr_w1,
    input  logic dis_wr,
    output logic pend_q
);
    typedef struct packed {
        logic pend;
    } pend_t;

    pend_t st_d, st_q;

    // Disable wins over everything; a new edge wins over write-1-to-clear.
    always_comb begin
        st_d = st_q;
        if (dis_wr)      st_d.pend = 1'b0;
        else if (rise)   st_d.pend = 1'b1;
        else if (clr_w1) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
    import dirq_pkg::*;
#(
    parameter int unsigned DATA_W = REG_W,
    parameter int unsigned LW     = LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dma_done,
    output logic [LW-1:0]     irq_level
);
    logic [LW-1:0] lvl_q;
    logic          en_q;
    logic          dis_wr;
    logic          edge_hit;
    logic          pend_q;
    logic          clr_w1;

    assign clr_w1 = wr_en & wr_data[PEND_POS];

    dirq_cfg #(.LVL_W(LW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_lvl    (wr_data[LW-1:0]),
        .wr_enable (wr_data[EN_POS]),
        .lvl_q     (lvl_q),
        .en_q      (en_q),
        .dis_wr    (dis_wr)
    );

    dirq_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (en_q & dma_done),
        .rise  (edge_hit)
    );

    dirq_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (edge_hit),
        .clr_w1 (clr_w1),
        .dis_wr (dis_wr),
        .pend_q (pend_q)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[LW-1:0]   = lvl_q;
        rd_data[EN_POS]   = en_q;
        rd_data[PEND_POS] = pend_q;
    end

    assign irq_level = (pend_q && (lvl_q != '0)) ? lvl_q : '0;
endmodule

// File: rtl/dirq_chk.sv
module dirq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       dma_done,
    input logic [7:0] rd_data,
    input logic [2:0] irq_level,
    input logic       rise
);
    AST_LVL0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2:0] == 3'd0) |-> (irq_level == 3'd0)); // R7

    AST_IRQ_FOLLOWS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && rd_data[2:0] != 3'd0) |-> (irq_level == rd_data[2:0])); // R7

    AST_SET_NEEDS_COND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[7]) |-> $past(rd_data[3] && dma_done)); // R3

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[3]) |=> !rd_data[7]); // R6

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7] && !rise) |=> !rd_data[7]); // R5

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !(wr_en && !wr_data[3])) |=> rd_data[7]); // R8

    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[7] && !rise) |=> !rd_data[7]); // R4
endmodule

bind dma_irq_ctl dirq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .dma_done  (dma_done),
    .rd_data   (rd_data),
    .irq_level (irq_level),
    .rise      (edge_hit)
);

// File: tb/sim_dma_irq_ctl.sv
`timescale 1ns/1ps
module sim_dma_irq_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       dma_done = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] irq_level;

    int compared = 0;
    int mismatched = 0;
    bit done_flag = 1'b0;

    typedef struct {
        logic [7:0] rd;
        logic [2:0] irq;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    dma_irq_ctl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .dma_done  (dma_done),
        .irq_level (irq_level)
    );

    task automatic cmp(input string tag, input logic [7:0] r, input logic [2:0] i);
        compared++;
        if (rd_data !== r || irq_level !== i) begin
            mismatched++;
            $display("FAIL %s: rd_data=%h irq_level=%0d expected rd_data=%h irq_level=%0d",
                     tag, rd_data, irq_level, r, i);
        end
    endtask

    // Monitor: compares one result per falling edge, after the registers settle.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, e.rd, e.irq);
            end
        end
    end

    // Driver: sets inputs at a falling edge and queues the result expected after the next rising edge.
    task automatic step(input logic w, input logic [7:0] d, input logic dn,
                        input logic [7:0] er, input logic [2:0] ei, input string tag);
        exp_t e;
        @(negedge clk);
        wr_en    = w;
        wr_data  = d;
        dma_done = dn;
        @(posedge clk);
        e.rd = er; e.irq = ei; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp("R1 reset held", 8'h00, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 after reset", 8'h00, 3'd0);

        step(1, 8'h05, 0, 8'h05, 3'd0, "R2 write level 5 disabled");
        step(0, 8'h00, 1, 8'h05, 3'd0, "R3 done ignored while disabled");
        step(1, 8'h0D, 1, 8'h0D, 3'd0, "R9 enable visible, pending not yet");
        step(0, 8'h00, 1, 8'h8D, 3'd5, "R9 enabling write with done high sets pending");
        step(0, 8'h00, 1, 8'h8D, 3'd5, "R3 pending holds");
        step(1, 8'h8D, 1, 8'h0D, 3'd0, "R5 write 1 clears pending");
        step(0, 8'h00, 1, 8'h0D, 3'd0, "R4 no re-set while condition stays high");
        step(0, 8'h00, 0, 8'h0D, 3'd0, "R4 condition falls");
        step(0, 8'h00, 1, 8'h8D, 3'd5, "R3 new rising edge sets pending");
        step(1, 8'h0D, 1, 8'h8D, 3'd5, "R5 write 0 to bit 7 keeps pending");
        step(1, 8'h08, 1, 8'h88, 3'd0, "R7 level 0 gives no request");
        step(1, 8'h0B, 1, 8'h8B, 3'd3, "R7 request at level 3");
        step(1, 8'h03, 1, 8'h03, 3'd0, "R6 disable clears pending");
        step(1, 8'h0B, 0, 8'h0B, 3'd0, "R2 re-enable with done low");
        step(0, 8'h00, 0, 8'h0B, 3'd0, "R3 idle, no edge");
        step(1, 8'h8B, 1, 8'h8B, 3'd3, "R8 edge beats write-1-clear");
        step(0, 8'h00, 1, 8'h8B, 3'd3, "R8 pending stays after tie");
        step(0, 8'h00, 0, 8'h8B, 3'd3, "R5 done falling keeps pending");

        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        done_flag = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule